// File: doc/BRIEF.md
# Half-Duplex Bidirectional Line Repeater

This block joins two open-drain, half-duplex data lines: one toward a host controller and one toward a card. Both lines are pulled up when idle. When nothing drives either line, both read high. When one line falls, that side becomes the master. The block then pulls the other side, the slave, low after a fixed delay. While a master is held, the slave line is not watched, so the low level that the block itself puts on the slave side cannot be taken as a new edge.

When the master side goes high again, the block drops the slave pull-down. It then drives the slave line high for one pulse of the same delay length, so that the line rises fast. After that pulse both sides return to idle.

Each side has three signals:
- a pad input, passed through a two-flop synchronizer;
- a registered pull-low enable;
- a registered active-pull-up enable.

A session enable input turns the repeater off. While it is low, the card side is never driven and the arbitration state is cleared. The delay `EDGE_DLY` is given in clock cycles and must be at least 4. At a 50 MHz clock, the default of 10 gives 200 ns. The delay plus the pull-up pulse must fit inside half a bit at the highest line rate.

Top module: `line_repeater`

## Requirements
- R1: After reset, and while both lines stay high, all four enables (`host_pull_low`, `host_pull_up`, `card_pull_low`, `card_pull_up`) stay low.
- R2: A falling edge on the host line makes the host the master. The card pull-low rises at the `EDGE_DLY`-th rising clock edge, counting as edge 1 the first edge that samples the host line low. It is still low after edge `EDGE_DLY`-1.
- R3: A falling edge on the card line, with the host line idle, makes the card the master. The host pull-low then rises with the same timing as in R2.
- R4: While a master is held, a low level or a falling edge on the slave line has no effect on the outputs. This covers both the block's own echo and an external pull on the slave line.
- R5: When the master line returns high, timing counts from edge 1, the first rising clock edge that samples the line high:
  - the slave pull-low falls at edge 3;
  - the slave pull-up is high at edge 3, then stays high for exactly `EDGE_DLY` cycles;
  - after the pull-up pulse, all enables are low.
- R6: If both lines are first sampled low at the same edge, the host side wins and the card side is pulled low.
- R7: One edge after `sess_en` is sampled low, all enables are low and the arbitration state returns to idle. Falling edges seen while the session is off start nothing. After re-enable, a new falling edge arbitrates normally.
- R8: A side's pull-low and pull-up are never high together. The two sides are never driven at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sess_en | input | 1 | Session enable; low forces everything idle |
| host_in | input | 1 | Sampled level of the host-side line |
| card_in | input | 1 | Sampled level of the card-side line |
| host_pull_low | output | 1 | Enable to pull the host line low |
| host_pull_up | output | 1 | Enable to drive the host line high actively |
| card_pull_low | output | 1 | Enable to pull the card line low |
| card_pull_up | output | 1 | Enable to drive the card line high actively |

## Verification
The bench drives each line change one nanosecond after a falling clock edge. The rising edge that follows is edge 1.

Each result is due at a fixed cycle:
- the slave pull-down, at falling edge `EDGE_DLY` after the stimulus;
- on release, the pull-down drop and the pull-up start, at falling edge 3;
- the end of the pull-up pulse, at falling edge `EDGE_DLY`+3;
- the effect of a session disable, at falling edge 1.

The driver queues each expected output vector together with the falling-edge count at which it is due. A monitor compares each entry against the outputs in exactly that cycle. An entry found late counts as a failure. Probes are placed one cycle before each switching point as well as on it, so a result that comes one cycle early or late is caught.

// File: rtl/lrep_pkg.sv
package lrep_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DELAY = 2'd1,
    PH_HOLD  = 2'd2,
    PH_BOOST = 2'd3
  } phase_t;

  typedef enum logic {
    SIDE_HOST = 1'b0,
    SIDE_CARD = 1'b1
  } side_t;
endpackage

// File: rtl/lrep_sync.sv
module lrep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pad_i,
  output logic lvl_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], pad_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl_o  = chain[STAGES-1];
  assign fall_o = prev & ~chain[STAGES-1];
endmodule

// File: rtl/lrep_ctrl.sv
module lrep_ctrl
  import lrep_pkg::*;
#(
  parameter int EDGE_DLY = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sess_en,
  input  logic [1:0] lvl,
  input  logic [1:0] fall,
  output logic       host_pull_low,
  output logic       host_pull_up,
  output logic       card_pull_low,
  output logic       card_pull_up
);
  localparam int CW       = $clog2(EDGE_DLY + 1);
  localparam int LOAD_DLY = EDGE_DLY - 4;
  localparam int LOAD_UP  = EDGE_DLY - 1;

  phase_t        phase;
  side_t         master;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !sess_en) begin
      phase         <= PH_IDLE;
      master        <= SIDE_HOST;
      cnt           <= '0;
      host_pull_low <= 1'b0;
      host_pull_up  <= 1'b0;
      card_pull_low <= 1'b0;
      card_pull_up  <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (fall[SIDE_HOST]) begin
            master <= SIDE_HOST;
            phase  <= PH_DELAY;
            cnt    <= CW'(LOAD_DLY);
          end else if (fall[SIDE_CARD]) begin
            master <= SIDE_CARD;
            phase  <= PH_DELAY;
            cnt    <= CW'(LOAD_DLY);
          end
        end
        PH_DELAY: begin
          if (cnt == '0) begin
            phase <= PH_HOLD;
            if (master == SIDE_HOST) card_pull_low <= 1'b1;
            else                     host_pull_low <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HOLD: begin
          if (lvl[master]) begin
            phase         <= PH_BOOST;
            cnt           <= CW'(LOAD_UP);
            host_pull_low <= 1'b0;
            card_pull_low <= 1'b0;
            if (master == SIDE_HOST) card_pull_up <= 1'b1;
            else                     host_pull_up <= 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            phase        <= PH_IDLE;
            host_pull_up <= 1'b0;
            card_pull_up <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  assert_host_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(host_pull_low && host_pull_up));
  assert_card_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(card_pull_low && card_pull_up));
  assert_one_side_R8: assert property (@(posedge clk) disable iff (rst)
    !((host_pull_low || host_pull_up) && (card_pull_low || card_pull_up)));
  assert_sess_off_R7: assert property (@(posedge clk) disable iff (rst)
    !sess_en |=> !(host_pull_low || host_pull_up || card_pull_low || card_pull_up));
  assert_card_boost_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(card_pull_low) && $past(sess_en)) |-> card_pull_up);
  assert_host_boost_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(host_pull_low) && $past(sess_en)) |-> host_pull_up);
endmodule

// File: rtl/line_repeater.sv
module line_repeater #(
  parameter int EDGE_DLY    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sess_en,
  input  logic host_in,
  input  logic card_in,
  output logic host_pull_low,
  output logic host_pull_up,
  output logic card_pull_low,
  output logic card_pull_up
);
  localparam int NSIDES = 2;

  logic [NSIDES-1:0] pad;
  logic [NSIDES-1:0] lvl;
  logic [NSIDES-1:0] fall;

  assign pad = {card_in, host_in};

  for (genvar s = 0; s < NSIDES; s++) begin : g_side
    lrep_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk    (clk),
      .rst    (rst),
      .pad_i  (pad[s]),
      .lvl_o  (lvl[s]),
      .fall_o (fall[s])
    );
  end

  lrep_ctrl #(.EDGE_DLY(EDGE_DLY)) i_ctrl (
    .clk           (clk),
    .rst           (rst),
    .sess_en       (sess_en),
    .lvl           (lvl),
    .fall          (fall),
    .host_pull_low (host_pull_low),
    .host_pull_up  (host_pull_up),
    .card_pull_low (card_pull_low),
    .card_pull_up  (card_pull_up)
  );
endmodule

// File: tb/test_line_repeater.sv
module test_line_repeater;
  localparam int DLY = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, sess_en, host_ext, card_ext;
  logic host_pull_low, host_pull_up, card_pull_low, card_pull_up;
  logic host_line, card_line;

  assign host_line = host_ext & ~host_pull_low;
  assign card_line = card_ext & ~card_pull_low;

  line_repeater #(.EDGE_DLY(DLY)) i_line_repeater (
    .clk(clk), .rst(rst), .sess_en(sess_en),
    .host_in(host_line), .card_in(card_line),
    .host_pull_low(host_pull_low), .host_pull_up(host_pull_up),
    .card_pull_low(card_pull_low), .card_pull_up(card_pull_up)
  );

  typedef struct {
    int       cyc;
    logic [3:0] exp;
    string    req;
  } item_t;

  item_t q[$];
  item_t it;
  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  int excl_viol = 0;
  logic [3:0] outs;
  assign outs = {host_pull_low, host_pull_up, card_pull_low, card_pull_up};

  // monitor: compare queued expectations in the cycle they are due
  always @(negedge clk) begin
    cyc++;
    if (!rst && ((host_pull_low && host_pull_up) || (card_pull_low && card_pull_up) ||
        ((host_pull_low || host_pull_up) && (card_pull_low || card_pull_up))))
      excl_viol++;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      it = q.pop_front();
      n_run++;
      if (it.cyc != cyc || outs !== it.exp) begin
        n_fail++;
        $display("FAIL %s cyc %0d (due %0d): outputs %b expected %b",
                 it.req, cyc, it.cyc, outs, it.exp);
      end
    end
  end

  task automatic push(input int off, input logic [3:0] e, input string r);
    item_t x;
    x.cyc = cyc + off; x.exp = e; x.req = r;
    q.push_back(x);
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic settle();
    while (q.size() > 0) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; sess_en = 1'b1; host_ext = 1'b1; card_ext = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    n_run++;
    if (outs !== 4'b0000) begin
      n_fail++;
      $display("FAIL R1 reset state: outputs %b expected 0000", outs);
    end
    rst = 1'b0;
    push(1, 4'b0000, "R1"); push(6, 4'b0000, "R1");
    settle();

    // R2: host master, card pull-low after DLY edges
    step(); host_ext = 1'b0;
    push(DLY-1, 4'b0000, "R2"); push(DLY, 4'b0010, "R2");
    settle();
    // R4: external pull on slave line while held is ignored
    step(); card_ext = 1'b0;
    push(4, 4'b0010, "R4"); push(8, 4'b0010, "R4");
    settle();
    step(); card_ext = 1'b1;
    push(4, 4'b0010, "R4");
    settle();
    // R5: release with boost pulse on card side
    step(); host_ext = 1'b1;
    push(2, 4'b0010, "R5"); push(3, 4'b0001, "R5");
    push(DLY+2, 4'b0001, "R5"); push(DLY+3, 4'b0000, "R5");
    push(DLY+8, 4'b0000, "R1");
    settle();

    // R3: card master
    step(); card_ext = 1'b0;
    push(DLY-1, 4'b0000, "R3"); push(DLY, 4'b1000, "R3");
    settle();
    step(); card_ext = 1'b1;
    push(2, 4'b1000, "R5"); push(3, 4'b0100, "R5");
    push(DLY+2, 4'b0100, "R5"); push(DLY+3, 4'b0000, "R5");
    settle();
    repeat (4) step();

    // R6: both fall together, host wins
    step(); host_ext = 1'b0; card_ext = 1'b0;
    push(DLY-1, 4'b0000, "R6"); push(DLY, 4'b0010, "R6"); push(DLY+4, 4'b0010, "R6");
    settle();
    step(); host_ext = 1'b1; card_ext = 1'b1;
    push(3, 4'b0001, "R6"); push(DLY+3, 4'b0000, "R6");
    settle();
    repeat (4) step();

    // R7: session disable
    step(); host_ext = 1'b0;
    push(DLY, 4'b0010, "R7");
    settle();
    step(); sess_en = 1'b0;
    push(1, 4'b0000, "R7");
    settle();
    step(); card_ext = 1'b0;
    push(DLY+2, 4'b0000, "R7");
    settle();
    step(); host_ext = 1'b1; card_ext = 1'b1;
    push(DLY+6, 4'b0000, "R7");
    settle();
    step(); sess_en = 1'b1;
    push(5, 4'b0000, "R7");
    settle();
    step(); card_ext = 1'b0;
    push(DLY, 4'b1000, "R7");
    settle();
    step(); card_ext = 1'b1;
    push(DLY+3, 4'b0000, "R7");
    settle();

    // R8: exclusivity observed every cycle
    n_run++;
    if (excl_viol != 0) begin
      n_fail++;
      $display("FAIL R8 exclusivity: %0d violating cycles expected 0", excl_viol);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule